// File: doc/BRIEF.md
# Atomic Set/Clear GPIO Port

This block is a 32-pin general-purpose I/O port on a simple register bus. Software never changes a pin through a plain data register. The output level and the output-driver enable are each changed through a pair of write-one-to-set and write-one-to-clear registers. Two agents can therefore change different pins without a read-modify-write race: a 0 in a write leaves the pin alone, and a 1 acts on that pin only.

Each pin has an output latch, an output-enable latch and a two-flop input synchronizer. The pin drives a tri-state pad interface made of a level, an enable and a returned input. A read-only register gives the synchronized pin levels. Read data is registered: it appears one clock after the request and holds until the next read.

The bus is one request per cycle: select, write flag, byte address and write data. The asynchronous active-low reset is released to the logic through a two-flop synchronizer. The bus must stay idle for two cycles after reset is released.

Top module: `gpio_sc_port`

## Requirements
- R1: While reset is asserted, and after it is released until the first write, `pad_out`, `pad_oe` and `bus_rdata` are all 0, so every pin is tri-state.
- R2: A write to byte offset 0x00 sets bit n of the output latch (`pad_out[n]`) for every data bit n that is 1, from the clock edge of the write. Bits written 0 keep their value.
- R3: A write to offset 0x10 clears bit n of the output latch for every data bit n that is 1. Bits written 0 keep their value.
- R4: A write to offset 0x20 sets the output enable `pad_oe[n]` for every data bit n that is 1. Bits written 0 keep their value.
- R5: A write to offset 0x30 clears `pad_oe[n]`, making pin n tri-state, for every data bit n that is 1. Bits written 0 keep their value.
- R6: A read of offset 0x40 returns in bit n the level of `pad_in[n]` as sampled two clock edges before the edge that captures the read.
- R7: A read of offset 0x00 or 0x10 returns the output latch. A read of offset 0x20 or 0x30 returns the output enables.
- R8: A read of any other offset returns 0. A write to any other offset, 0x40 included, changes neither `pad_out` nor `pad_oe`.
- R9: `bus_rdata` is loaded on the clock edge of a read (`bus_sel`=1, `bus_we`=0). It keeps its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data, bit n for pin n |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Level returned from each pad |
| pad_out | output | 32 | Output level to each pad |
| pad_oe | output | 32 | Output-driver enable to each pad |

## Verification
Sparse masks of set and clear bits are applied over latches already holding mixed values. This shows that pins written 0 are left untouched, which a design that overwrites the whole latch would break. The input path is read right after `pad_in` changes and again later, which tells a correct two-edge delay from a shorter or longer one. Writes and reads to unmapped offsets, including writes to the read-only input offset, separate a full address decode from a partial one. A long run of random accesses with a changing `pad_in` is compared every clock against a behavioural model kept in the bench.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  localparam int unsigned OFS_OUT_SET = 'h00;
  localparam int unsigned OFS_OUT_CLR = 'h10;
  localparam int unsigned OFS_OE_SET  = 'h20;
  localparam int unsigned OFS_OE_CLR  = 'h30;
  localparam int unsigned OFS_PIN_LVL = 'h40;

  typedef enum logic [1:0] {
    RSRC_ZERO = 2'd0,
    RSRC_OUT  = 2'd1,
    RSRC_OE   = 2'd2,
    RSRC_PIN  = 2'd3
  } rd_src_e;

  typedef struct packed {
    logic out_set;
    logic out_clr;
    logic oe_set;
    logic oe_clr;
  } wr_strb_t;
endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
  import gpio_sc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output wr_strb_t          wr_strb,
  output rd_src_e           rd_src
);
  always_comb begin
    wr_strb = '0;
    rd_src  = RSRC_ZERO;
    if (sel) begin
      if (addr == ADDR_W'(OFS_OUT_SET)) begin
        wr_strb.out_set = we;
        rd_src          = RSRC_OUT;
      end else if (addr == ADDR_W'(OFS_OUT_CLR)) begin
        wr_strb.out_clr = we;
        rd_src          = RSRC_OUT;
      end else if (addr == ADDR_W'(OFS_OE_SET)) begin
        wr_strb.oe_set  = we;
        rd_src          = RSRC_OE;
      end else if (addr == ADDR_W'(OFS_OE_CLR)) begin
        wr_strb.oe_clr  = we;
        rd_src          = RSRC_OE;
      end else if (addr == ADDR_W'(OFS_PIN_LVL)) begin
        rd_src          = RSRC_PIN;
      end
    end
  end
endmodule

// File: rtl/gpio_sc_latch.sv
module gpio_sc_latch #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_v,
  input  logic [WIDTH-1:0] clr_v,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_d;
  logic             q_en;

  // a clear of a pin takes precedence over a set of the same pin
  always_comb begin
    q_en = |(set_v | clr_v);
    q_d  = (q | set_v) & ~clr_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

  // R2 R4
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_v & ~clr_v) != '0) |=>
      ((q & $past(set_v & ~clr_v)) == $past(set_v & ~clr_v)));

  // R3 R5
  latch_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_v != '0) |=> ((q & $past(clr_v)) == '0));

  // R2 R3 R4 R5
  latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((q ^ $past(q)) & ~$past(set_v | clr_v)) == '0));
endmodule

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_sc_port.sv
module gpio_sc_port
  import gpio_sc_pkg::*;
#(
  parameter int unsigned PINS        = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);
  localparam int unsigned RST_STAGES = 2;

  // reset: asserted at once, released through a short flop chain
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = rst_pipe[RST_STAGES-1];

  wr_strb_t        wr_strb;
  rd_src_e         rd_src;
  logic [PINS-1:0] out_set_v, out_clr_v, oe_set_v, oe_clr_v;
  logic [PINS-1:0] pin_lvl;
  logic [PINS-1:0] rdata_d;
  logic            rdata_en;

  gpio_sc_decode #(.ADDR_W(ADDR_W)) u_decode (
    .sel     (bus_sel),
    .we      (bus_we),
    .addr    (bus_addr),
    .wr_strb (wr_strb),
    .rd_src  (rd_src)
  );

  always_comb begin
    out_set_v = {PINS{wr_strb.out_set}} & bus_wdata;
    out_clr_v = {PINS{wr_strb.out_clr}} & bus_wdata;
    oe_set_v  = {PINS{wr_strb.oe_set}}  & bus_wdata;
    oe_clr_v  = {PINS{wr_strb.oe_clr}}  & bus_wdata;
  end

  gpio_sc_latch #(.WIDTH(PINS)) u_out_latch (
    .clk   (clk),
    .rst_n (core_rst_n),
    .set_v (out_set_v),
    .clr_v (out_clr_v),
    .q     (pad_out)
  );

  gpio_sc_latch #(.WIDTH(PINS)) u_oe_latch (
    .clk   (clk),
    .rst_n (core_rst_n),
    .set_v (oe_set_v),
    .clr_v (oe_clr_v),
    .q     (pad_oe)
  );

  gpio_sc_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d     (pad_in),
    .q     (pin_lvl)
  );

  // read mux and read-data register
  always_comb begin
    rdata_en = bus_sel & ~bus_we;
    unique case (rd_src)
      RSRC_OUT: rdata_d = pad_out;
      RSRC_OE:  rdata_d = pad_oe;
      RSRC_PIN: rdata_d = pin_lvl;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)   bus_rdata <= '0;
    else if (rdata_en) bus_rdata <= rdata_d;
  end

  logic addr_mapped;
  assign addr_mapped = (bus_addr == ADDR_W'(OFS_OUT_SET)) || (bus_addr == ADDR_W'(OFS_OUT_CLR)) ||
                       (bus_addr == ADDR_W'(OFS_OE_SET))  || (bus_addr == ADDR_W'(OFS_OE_CLR))  ||
                       (bus_addr == ADDR_W'(OFS_PIN_LVL));

  // R8
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bus_sel && !bus_we && !addr_mapped) |=> (bus_rdata == '0));

  // R8
  unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bus_sel && bus_we && (!addr_mapped || bus_addr == ADDR_W'(OFS_PIN_LVL)))
      |=> ($stable(pad_out) && $stable(pad_oe)));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(bus_sel && !bus_we) |=> $stable(bus_rdata));
endmodule

// File: tb/gpio_sc_port_bench.sv
`timescale 1ns/1ps
module gpio_sc_port_bench;
  localparam int PINS = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            bus_sel, bus_we;
  logic [7:0]      bus_addr;
  logic [PINS-1:0] bus_wdata, bus_rdata, pad_in, pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_sc_port u_gpio_sc_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // behavioural reference
  logic [PINS-1:0] m_out, m_oe, m_rd;
  logic [PINS-1:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = '0; m_oe = '0; m_rd = '0;
      hist.delete();
      hist.push_back('0);
      hist.push_back('0);
    end else begin
      if (bus_sel && !bus_we) begin
        case (bus_addr)
          8'h00, 8'h10: m_rd = m_out;
          8'h20, 8'h30: m_rd = m_oe;
          8'h40:        m_rd = hist[0];
          default:      m_rd = '0;
        endcase
      end else if (bus_sel && bus_we) begin
        case (bus_addr)
          8'h00: m_out = m_out | bus_wdata;
          8'h10: m_out = m_out & ~bus_wdata;
          8'h20: m_oe  = m_oe | bus_wdata;
          8'h30: m_oe  = m_oe & ~bus_wdata;
          default: ;
        endcase
      end
      hist.push_back(pad_in);
      while (hist.size() > 2) void'(hist.pop_front());
    end
  end

  task automatic chk(string tag, string what, logic [PINS-1:0] act, logic [PINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "pad_out", pad_out, m_out);
    chk(tag, "pad_oe", pad_oe, m_oe);
    chk(tag, "bus_rdata", bus_rdata, m_rd);
  endtask

  // drive one request, let one edge pass, compare away from the edge
  task automatic acc(bit sel, bit we, logic [7:0] a, logic [PINS-1:0] d, string tag);
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) acc(1'b0, 1'b0, 8'h00, '0, tag);
  endtask

  function automatic string tag_of(bit we, logic [7:0] a);
    if (we) begin
      case (a)
        8'h00: return "R2";
        8'h10: return "R3";
        8'h20: return "R4";
        8'h30: return "R5";
        default: return "R8";
      endcase
    end
    case (a)
      8'h00, 8'h10, 8'h20, 8'h30: return "R7";
      8'h40: return "R6";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [10] = '{8'h00, 8'h10, 8'h20, 8'h30, 8'h40,
                               8'h04, 8'h44, 8'h50, 8'hFF, 8'h18};
    rst_n = 1'b0; bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    repeat (3) begin
      @(negedge clk);
      compare("R1");
    end
    rst_n = 1'b1;
    idle(4, "R1");

    // R2: sparse sets build up, zeros leave pins alone
    acc(1, 1, 8'h00, 32'h0000_00F0, "R2");
    acc(1, 1, 8'h00, 32'hA500_0000, "R2");
    // R3: clear a subset
    acc(1, 1, 8'h10, 32'h0000_0030, "R3");
    acc(1, 1, 8'h10, 32'h0000_0000, "R3");
    // R7 read back of output latch through both offsets
    acc(1, 0, 8'h00, '0, "R7");
    acc(1, 0, 8'h10, '0, "R7");
    // R4 / R5
    acc(1, 1, 8'h20, 32'hFFFF_0000, "R4");
    acc(1, 1, 8'h30, 32'h0F00_0000, "R5");
    acc(1, 0, 8'h20, '0, "R7");
    acc(1, 0, 8'h30, '0, "R7");
    // R9: idle and writes do not disturb read data
    idle(3, "R9");
    acc(1, 1, 8'h00, 32'h0000_0001, "R9");

    // R6: latency of input path
    pad_in = 32'h1234_5678;
    acc(1, 0, 8'h40, '0, "R6");
    acc(1, 0, 8'h40, '0, "R6");
    acc(1, 0, 8'h40, '0, "R6");
    for (int b = 0; b < PINS; b += 5) begin
      pad_in = 32'h1 << b;
      acc(1, 0, 8'h40, '0, "R6");
    end
    idle(2, "R6");
    acc(1, 0, 8'h40, '0, "R6");

    // R8: unmapped and read-only offsets
    acc(1, 1, 8'h04, 32'hFFFF_FFFF, "R8");
    acc(1, 1, 8'h40, 32'hFFFF_FFFF, "R8");
    acc(1, 1, 8'h50, 32'hFFFF_FFFF, "R8");
    acc(1, 1, 8'hFF, 32'hFFFF_FFFF, "R8");
    acc(1, 0, 8'h08, '0, "R8");
    acc(1, 0, 8'h00, '0, "R7");
    acc(1, 0, 8'h31, '0, "R8");

    // mixed random traffic with a changing input
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      bit         we;
      a  = addrs[$urandom_range(0, 9)];
      we = $urandom_range(0, 1);
      pad_in = $urandom;
      acc($urandom_range(0, 3) != 0, we, a, $urandom & $urandom, tag_of(we, a));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule